// File: doc/BRIEF.md
# Split Transaction Timeout Timer

This block times how long a requester has been waiting for the response half of a split bus transaction. Two control registers set the interval. The seconds register holds whole seconds in its three lowest bits. The fraction register holds a 13-bit count of bus cycles in its thirteen highest bits. Each bus cycle lasts 125 µs, so 8192 fraction units make up roughly one second. The two fields join into one unit count: seconds times 8192 plus the fraction.

A simple register port accepts single-quadlet writes and reads. A `tick` input pulses once per bus cycle. A `start` pulse loads the countdown for the one outstanding transaction. A `cancel` pulse stops the countdown quietly, for example when the response arrives. If the interval runs out first, `expired` pulses for one clock. The count loaded on start is one unit longer than programmed, so the timer can never fire before the programmed time.

Top module: `split_timeout_timer`

## Requirements
- R1: After reset, the seconds register (`reg_sel`=0) reads 0x00000000 and the fraction register (`reg_sel`=1) reads 0x19000000, which is 800 units in bits 31:19. `busy` and `expired` are low.
- R2: A write with `reg_sel`=0 keeps only bits 2:0 of the data. A read returns those bits, and bits 31:3 read as zero.
- R3: A write with `reg_sel`=1 keeps only bits 31:19 of the data. A read returns those bits, and bits 18:0 read as zero.
- R4: After `start`, `expired` goes high only after exactly U+1 `tick` pulses, where U = seconds*8192 + fraction. Clock cycles without `tick` do not advance the count. With U=0, the first tick expires the timer.
- R5: `expired` is high for exactly one clock. `busy` falls at the same edge, and `expired` stays low after that until the next `start`.
- R6: `cancel` ends the countdown: `busy` falls and `expired` is never raised for that transaction.
- R7: Register writes made while `busy` is high do not change the running countdown. The new value applies from the next `start`.
- R8: `tick` pulses while idle have no effect, and `expired` stays low.
- R9: `start` while `busy` restarts the countdown from U+1. `start` takes priority over `cancel` and `tick` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register selected by `reg_sel` |
| reg_sel | input | 1 | 0 selects the seconds register, 1 selects the fraction register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register; valid in the same cycle |
| tick | input | 1 | One pulse per 125 µs bus cycle |
| start | input | 1 | Begin timing a transaction |
| cancel | input | 1 | Stop timing without expiry |
| busy | output | 1 | Countdown in progress |
| expired | output | 1 | One-clock pulse when the interval has elapsed |

## Verification
A register write shows on `reg_rdata` in the cycle after the write edge, because the read mux is combinational over the stored fields. `busy` rises at the edge that samples `start`. `expired` is registered, so it is high in the cycle that directly follows the edge that sampled the final `tick`, and `busy` is low in that same cycle. The bench drives every input on the falling edge and reads results at the next falling edge. Each expiry check therefore lands in the one cycle where the pulse is due, and the following cycle confirms that the pulse has ended.

// File: rtl/stt_pkg.sv
package stt_pkg;
    parameter int DATA_W     = 32;
    parameter int SEC_W      = 3;
    parameter int FRAC_W     = 13;
    parameter int FRAC_RESET = 800;
    localparam int FRAC_LSB  = DATA_W - FRAC_W;
    localparam int UNIT_W    = SEC_W + FRAC_W;
    localparam int CNT_W     = UNIT_W + 1;

    typedef struct packed {
        logic [SEC_W-1:0]  secs;
        logic [FRAC_W-1:0] frac;
    } tmo_regs_t;

    typedef struct packed {
        logic             busy;
        logic             expired;
        logic [CNT_W-1:0] cnt;
    } tmo_cnt_t;
endpackage

// File: rtl/stt_regs.sv
module stt_regs
    import stt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [UNIT_W-1:0] units
);
    tmo_regs_t regs_d, regs_q;
    logic      unused_bits;

    assign unused_bits = ^wdata[FRAC_LSB-1:SEC_W];

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            if (sel) regs_d.frac = wdata[DATA_W-1:FRAC_LSB];
            else     regs_d.secs = wdata[SEC_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.secs <= '0;
            regs_q.frac <= FRAC_W'(FRAC_RESET);
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (sel) rdata[DATA_W-1:FRAC_LSB] = regs_q.frac;
        else     rdata[SEC_W-1:0]         = regs_q.secs;
    end

    // seconds field weighs 2^FRAC_W units, so concatenation is the sum
    assign units = {regs_q.secs, regs_q.frac};

    AST_SECS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !sel |=> units[UNIT_W-1:FRAC_W] == $past(wdata[SEC_W-1:0])); // R2
    AST_FRAC_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && sel |=> units[FRAC_W-1:0] == $past(wdata[DATA_W-1:FRAC_LSB])); // R3
endmodule

// File: rtl/stt_count.sv
module stt_count
    import stt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cancel,
    input  logic              tick,
    input  logic [UNIT_W-1:0] units,
    output logic              busy,
    output logic              expired
);
    tmo_cnt_t c_d, c_q;

    always_comb begin
        c_d         = c_q;
        c_d.expired = 1'b0;
        if (start) begin
            c_d.cnt  = CNT_W'(units) + CNT_W'(1);
            c_d.busy = 1'b1;
        end else if (cancel) begin
            c_d.cnt  = '0;
            c_d.busy = 1'b0;
        end else if (tick && c_q.busy) begin
            if (c_q.cnt == CNT_W'(1)) begin
                c_d.cnt     = '0;
                c_d.busy    = 1'b0;
                c_d.expired = 1'b1;
            end else begin
                c_d.cnt = c_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign busy    = c_q.busy;
    assign expired = c_q.expired;

    AST_EXP_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        expired |-> $past(tick) && $past(busy) && !busy); // R4
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !start && !cancel && !tick |=> $stable(c_q.cnt) && busy); // R4
    AST_EXP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        expired && !start |=> !expired); // R5
    AST_CANCEL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        cancel && !start |=> !expired && !busy); // R6
    AST_IDLE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !start |=> !expired); // R8
    AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy && c_q.cnt == CNT_W'($past(units)) + CNT_W'(1)); // R9
endmodule

// File: rtl/split_timeout_timer.sv
module split_timeout_timer
    import stt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              tick,
    input  logic              start,
    input  logic              cancel,
    output logic              busy,
    output logic              expired
);
    logic [UNIT_W-1:0] units;

    stt_regs i_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (reg_wr),
        .sel   (reg_sel),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .units (units)
    );

    stt_count i_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .cancel  (cancel),
        .tick    (tick),
        .units   (units),
        .busy    (busy),
        .expired (expired)
    );
endmodule

// File: tb/test_split_timeout_timer.sv
module test_split_timeout_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tick = 1'b0;
    logic        start = 1'b0;
    logic        cancel = 1'b0;
    logic        busy;
    logic        expired;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    split_timeout_timer i_split_timeout_timer (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick(tick),
        .start(start), .cancel(cancel), .busy(busy), .expired(expired)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic sel, input logic [31:0] data);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = data;
        step();
        reg_wr = 1'b0;
    endtask

    task automatic rd_check(input logic sel, input logic [31:0] exp, input string req);
        reg_sel = sel;
        #1;
        check(reg_rdata === exp, req, reg_rdata, exp);
    endtask

    task automatic pulse_start();
        start = 1'b1; step(); start = 1'b0;
    endtask

    task automatic pulse_cancel();
        cancel = 1'b1; step(); cancel = 1'b0;
    endtask

    // n ticks, each followed by an idle cycle when gap is set; counts expiries seen
    task automatic ticks(input int n, input bit gap, output int fires);
        fires = 0;
        for (int i = 0; i < n; i++) begin
            tick = 1'b1; step(); tick = 1'b0;
            if (expired) fires++;
            if (gap) begin
                step();
                if (expired) fires++;
            end
        end
    endtask

    // expects expiry exactly on tick number n
    task automatic expect_expiry(input int n, input bit gap, input string req);
        int early;
        ticks(n - 1, gap, early);
        check(early == 0, {req, " no early expiry"}, early, 0);
        tick = 1'b1; step(); tick = 1'b0;
        check(expired === 1'b1, {req, " expiry on final tick"}, {31'b0, expired}, 1);
        check(busy === 1'b0, {req, " busy low at expiry"}, {31'b0, busy}, 0);
    endtask

    task automatic t_reset();
        rd_check(1'b0, 32'h0000_0000, "R1 seconds reset");
        rd_check(1'b1, 32'h1900_0000, "R1 fraction reset");
        check(busy === 1'b0 && expired === 1'b0, "R1 outputs idle", {30'b0, busy, expired}, 0);
    endtask

    task automatic t_masks();
        wr(1'b0, 32'hFFFF_FFFF);
        rd_check(1'b0, 32'h0000_0007, "R2 seconds mask");
        wr(1'b1, 32'hFFFF_FFFF);
        rd_check(1'b1, 32'hFFF8_0000, "R3 fraction mask");
        wr(1'b0, 32'h0000_0000);
        wr(1'b1, 32'd800 << 19);
        rd_check(1'b1, 32'h1900_0000, "R3 fraction restore");
    endtask

    task automatic t_default();
        pulse_start();
        check(busy === 1'b1, "R4 busy after start", {31'b0, busy}, 1);
        expect_expiry(801, 1'b0, "R4 default 800 units");
        step();
        check(expired === 1'b0, "R5 pulse one clock", {31'b0, expired}, 0);
    endtask

    task automatic t_short_gap();
        wr(1'b1, 32'd3 << 19);
        pulse_start();
        expect_expiry(4, 1'b1, "R4 idle cycles do not count");
        step();
        check(expired === 1'b0 && busy === 1'b0, "R5 stays low after pulse", {30'b0, busy, expired}, 0);
    endtask

    task automatic t_combined();
        wr(1'b0, 32'd1);
        wr(1'b1, 32'd2 << 19);
        pulse_start();
        expect_expiry(8195, 1'b0, "R4 seconds plus fraction");
        wr(1'b0, 32'd0);
    endtask

    task automatic t_zero();
        wr(1'b1, 32'h0000_0000);
        pulse_start();
        expect_expiry(1, 1'b0, "R4 zero interval");
    endtask

    task automatic t_cancel_idle();
        int f;
        wr(1'b1, 32'd3 << 19);
        pulse_start();
        ticks(2, 1'b0, f);
        pulse_cancel();
        check(busy === 1'b0 && expired === 1'b0, "R6 cancel stops", {30'b0, busy, expired}, 0);
        ticks(10, 1'b0, f);
        check(f == 0, "R8 idle ticks ignored", f, 0);
    endtask

    task automatic t_write_during();
        int f;
        wr(1'b1, 32'd3 << 19);
        pulse_start();
        ticks(2, 1'b0, f);
        wr(1'b1, 32'd10 << 19);
        check(busy === 1'b1, "R7 write keeps busy", {31'b0, busy}, 1);
        expect_expiry(2, 1'b0, "R7 running count unchanged");
        pulse_start();
        expect_expiry(11, 1'b0, "R7 new value on next start");
    endtask

    task automatic t_restart();
        int f;
        wr(1'b1, 32'd3 << 19);
        pulse_start();
        ticks(3, 1'b0, f);
        start = 1'b1; tick = 1'b1; cancel = 1'b1;
        step();
        start = 1'b0; tick = 1'b0; cancel = 1'b0;
        check(busy === 1'b1 && f == 0, "R9 start wins and restarts", {31'b0, busy}, 1);
        expect_expiry(4, 1'b0, "R9 full count after restart");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual 0x%08h expected 0x%08h", 1, 0);
        finish_run();
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_masks();
        t_default();
        t_short_gap();
        t_combined();
        t_zero();
        t_cancel_idle();
        t_write_during();
        t_restart();
        finish_run();
    end
endmodule